// File: doc/BRIEF.md
# Multi-Chain Programmable Clock Divider

This block divides its input clock by 24, 25, 26 or 27. Each ratio has its own chain of small fixed dividers. Every chain steps on the same input clock, and a 2-bit select picks which chain drives the output. The chain for ratio 24 is a divide-by-8 stage made of three cascaded toggle stages, followed by a divide-by-3 stage. The chain for 25 is two divide-by-5 stages. The chain for 26 is a divide-by-2 stage ahead of a divide-by-13 stage. The chain for 27 is three divide-by-3 stages.

The output is a one-input-cycle pulse that repeats once per selected ratio. Its duty cycle is not balanced, which suits an edge-triggered phase detector downstream. Only the selected chain is enabled. Every other chain is held cleared to save switching activity. When a chain is enabled again it starts from its cleared state, so the delay to its first pulse is fixed. Everything runs in one clock domain with a synchronous active-high reset.

Top module: `clkdiv_multichain`

## Requirements
- R1: While `rst` is high, every clock edge leaves `clk_out` low and `chain_en` all zero.
- R2: Select encoding is `ratio_sel` 00 for 24, 01 for 25, 10 for 26 and 11 for 27. On each edge with `rst` low, `chain_en` takes the one-hot value with bit `ratio_sel` set: bit 0 is the 24 chain and bit 3 is the 27 chain.
- R3: Once running, `clk_out` is high for exactly one input cycle, and its rising edges are exactly N input cycles apart, where N is the selected ratio.
- R4: Edge 1 is the first edge at which `rst` is low, or the first edge after `ratio_sel` changes. The first `clk_out` pulse is produced by edge N+1, and `clk_out` stays low after edges 1 through N.
- R5: When `ratio_sel` changes, the previously selected chain produces no pulse on `clk_out`, even if its pulse was due on edge 1.
- R6: A chain that has been deselected and is selected again restarts from its cleared state, with the timing of R4, whatever count it held when it was left.
- R7: Changes of `ratio_sel` while `rst` is high have no effect: `chain_en` stays zero and `clk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Ratio select: 00=24, 01=25, 10=26, 11=27 |
| chain_en | output | 4 | One-hot enable of the running chain (bit 0 = 24 ... bit 3 = 27) |
| clk_out | output | 1 | Divided clock, one-cycle high pulse per period |

## Verification
Two events can land on the same edge. One is the old chain's terminal pulse. The other is the enable handover caused by a change of the select. The bench runs the 24 chain and waits until its next pulse is one edge away. It then changes the select to 27 in that same gap, so the old chain wraps on exactly the edge where the enables swap. The run passes only if `clk_out` shows no pulse there, and the first pulse then arrives 28 edges after the change, as the fresh 27 chain demands.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned NUM_CHAINS = 4;
    localparam int unsigned SEL_W      = $clog2(NUM_CHAINS);
    localparam int unsigned MAX_STAGES = 3;
    localparam int unsigned BASE_RATIO = 24;

    typedef logic [SEL_W-1:0]      ratio_sel_t;
    typedef logic [NUM_CHAINS-1:0] chain_vec_t;

    // Link between two cascaded stages: the advance strobe entering a stage
    // and the wrap strobe leaving it.
    typedef struct packed {
        logic adv;
        logic wrap;
    } stage_link_t;

    // Ratio of each stage of each chain; 1 means the slot is a pass-through.
    function automatic int unsigned stage_ratio(input int unsigned chain,
                                                input int unsigned stage);
        int unsigned r;
        r = 1;
        case (chain)
            0: case (stage) 0: r = 8; 1: r = 3;  default: r = 1; endcase
            1: case (stage) 0: r = 5; 1: r = 5;  default: r = 1; endcase
            2: case (stage) 0: r = 2; 1: r = 13; default: r = 1; endcase
            default: r = 3;
        endcase
        return r;
    endfunction

    function automatic int unsigned chain_ratio(input int unsigned chain);
        int unsigned p;
        p = 1;
        for (int unsigned s = 0; s < MAX_STAGES; s++) p = p * stage_ratio(chain, s);
        return p;
    endfunction

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/div_stage.sv
module div_stage #(
    parameter int unsigned RATIO = 3
) (
    input  logic clk,
    input  logic clr,
    input  logic adv,
    output logic wrap
);
    localparam int unsigned CW = (RATIO > 2) ? $clog2(RATIO) : 1;

    generate
        if (clkdiv_pkg::is_pow2(RATIO)) begin : g_toggle
            // Cascade of toggle bits: bit b flips when all lower bits are set.
            logic [CW-1:0] tq;
            logic [CW:0]   carry;
            assign carry[0] = adv;
            for (genvar b = 0; b < CW; b++) begin : g_bit
                assign carry[b+1] = carry[b] & tq[b];
                always_ff @(posedge clk) begin
                    if (clr)           tq[b] <= 1'b0;
                    else if (carry[b]) tq[b] <= ~tq[b];
                end
            end
            assign wrap = carry[CW];
        end else begin : g_count
            // Counter with terminal-count restart for odd ratios.
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (clr)      cnt <= '0;
                else if (adv) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
            assign wrap = adv && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/div_chain.sv
module div_chain #(
    parameter int unsigned CHAIN = 0
) (
    input  logic clk,
    input  logic clr,
    output logic pulse
);
    import clkdiv_pkg::*;

    stage_link_t link [MAX_STAGES];
    logic        last_wrap;

    generate
        for (genvar s = 0; s < MAX_STAGES; s++) begin : g_stage
            localparam int unsigned R = stage_ratio(CHAIN, s);
            if (s == 0) begin : g_head
                assign link[s].adv = 1'b1;
            end else begin : g_tail
                assign link[s].adv = link[s-1].wrap;
            end
            if (R > 1) begin : g_div
                div_stage #(.RATIO(R)) u_stage (
                    .clk  (clk),
                    .clr  (clr),
                    .adv  (link[s].adv),
                    .wrap (link[s].wrap)
                );
            end else begin : g_pass
                assign link[s].wrap = link[s].adv;
            end
        end
    endgenerate

    assign last_wrap = link[MAX_STAGES-1].wrap;

    always_ff @(posedge clk) begin
        if (clr) pulse <= 1'b0;
        else     pulse <= last_wrap;
    end

endmodule

// File: rtl/chain_enable_ctrl.sv
module chain_enable_ctrl (
    input  logic                   clk,
    input  logic                   rst,
    input  clkdiv_pkg::ratio_sel_t ratio_sel,
    output clkdiv_pkg::chain_vec_t chain_en
);
    import clkdiv_pkg::*;

    chain_vec_t en_next;

    always_comb begin
        en_next = '0;
        for (int unsigned i = 0; i < NUM_CHAINS; i++)
            en_next[i] = (ratio_sel == SEL_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) chain_en <= '0;
        else     chain_en <= en_next;
    end

endmodule

// File: rtl/clkdiv_multichain.sv
module clkdiv_multichain (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    output logic [3:0] chain_en,
    output logic       clk_out
);
    import clkdiv_pkg::*;

    chain_vec_t en_q;
    chain_vec_t chain_pulse;

    chain_enable_ctrl u_en (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .chain_en  (en_q)
    );

    generate
        for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
            logic clr_c;
            assign clr_c = rst | ~en_q[c];
            div_chain #(.CHAIN(c)) u_chain (
                .clk   (clk),
                .clr   (clr_c),
                .pulse (chain_pulse[c])
            );
        end
    endgenerate

    assign chain_en = en_q;
    assign clk_out  = chain_pulse[ratio_sel];

endmodule

// File: rtl/clkdiv_multichain_chk.sv
module clkdiv_multichain_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ratio_sel,
    input logic [3:0] chain_en,
    input logic       clk_out
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (chain_en == 4'b0000 && !clk_out));

    // R2
    en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chain_en));

    // R2
    en_follows_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> chain_en == (4'b0001 << $past(ratio_sel)));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        clk_out |=> !clk_out);

    // R5
    no_runt_on_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ratio_sel != $past(ratio_sel)) |-> !clk_out);

endmodule

bind clkdiv_multichain clkdiv_multichain_chk u_chk (.*);

// File: tb/tb_clkdiv_multichain.sv
module tb_clkdiv_multichain;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ratio_sel = 2'b00;
    logic [3:0] chain_en;
    logic       clk_out;

    int errors = 0;
    int checks = 0;

    clkdiv_multichain dut (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .chain_en  (chain_en),
        .clk_out   (clk_out)
    );

    always #10ns clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [1:0] s);
        return 24 + int'(s);
    endfunction

    // Called right after the stimulus edge gap; edge 1 is the next posedge.
    task automatic expect_first(input int n, input string req);
        int at = 0;
        for (int k = 1; k <= n + 6 && at == 0; k++) begin
            @(negedge clk);
            if (clk_out) at = k;
        end
        check(at == n + 1, req, "first pulse edge", at, n + 1);
    endtask

    // Called at a negedge where clk_out is high.
    task automatic expect_periods(input int n, input int count, input string req);
        for (int p = 0; p < count; p++) begin
            int k = 0;
            @(negedge clk);
            k = 1;
            check(!clk_out, req, "pulse width (out after 1 cycle)", int'(clk_out), 0);
            while (!clk_out && k < n + 6) begin
                @(negedge clk);
                k++;
            end
            check(k == n, req, "period", k, n);
        end
    endtask

    task automatic t_ratio(input logic [1:0] s);
        @(negedge clk);
        rst = 1'b1;
        ratio_sel = s;
        repeat (3) @(negedge clk);
        check(chain_en == 4'b0000, "R1", "chain_en in reset", int'(chain_en), 0);
        check(!clk_out, "R1", "clk_out in reset", int'(clk_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(chain_en == (4'b0001 << s), "R2", "chain_en decode",
              int'(chain_en), int'(4'b0001 << s));
        // one edge already consumed; first pulse at edge n+1 means n more
        begin
            int at = 0;
            for (int k = 2; k <= ratio_of(s) + 6 && at == 0; k++) begin
                @(negedge clk);
                if (clk_out) at = k;
            end
            check(at == ratio_of(s) + 1, "R4", "first pulse after reset", at, ratio_of(s) + 1);
        end
        expect_periods(ratio_of(s), 3, "R3");
    endtask

    task automatic t_switch_on_pulse();
        t_ratio(2'b00);
        // at a pulse now; old chain's next pulse would appear 24 negedges on
        repeat (23) @(negedge clk);
        ratio_sel = 2'b11;
        expect_first(27, "R5");
        expect_periods(27, 2, "R5");
    endtask

    task automatic t_reselect();
        // running 27 chain, leave it mid-count
        repeat (11) @(negedge clk);
        ratio_sel = 2'b01;
        expect_first(25, "R6");
        repeat (7) @(negedge clk);
        ratio_sel = 2'b11;
        expect_first(27, "R6");
        expect_periods(27, 1, "R6");
        repeat (5) @(negedge clk);
        ratio_sel = 2'b10;
        expect_first(26, "R6");
    endtask

    task automatic t_sel_in_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            ratio_sel = 2'(i);
            @(negedge clk);
            check(chain_en == 4'b0000, "R7", "chain_en with sel moving in reset",
                  int'(chain_en), 0);
            check(!clk_out, "R7", "clk_out with sel moving in reset", int'(clk_out), 0);
        end
    endtask

    initial begin
        #4ms;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) t_ratio(2'(s));
        t_switch_on_pulse();
        t_reselect();
        t_sel_in_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule